// File: doc/BRIEF.md
# Boundary Scan Register Cell Bank

This block is a bank of independent boundary-scan cells, one per lane, each sitting between a device pin and the core logic. In normal operation each lane passes its parallel input straight to its parallel output, so functional traffic is untouched. In test operation a lane has two storage stages:

- A capture/shift stage that either samples the parallel input or takes the serial input.
- A hold stage that takes a copy of the capture/shift stage on command and drives the parallel output when test mode is selected.

The cell logic is the same whether the lane faces an input pin or an output pin. At an input pin, the parallel input comes from the board and the parallel output feeds the core. At an output pin, the parallel input comes from the core and the parallel output drives the board. All strobes are enables sampled on one common test clock. Sequencing the strobes, decoding instructions and linking lanes into a chain are the job of surrounding blocks.

Top module: `bsr_cell_bank`

## Requirements
- R1: While `test_mode` is 0, `par_out[i]` equals `par_in[i]` in the same cycle, with no clock edge in between.
- R2: On a clock edge with `cap_en`=1 and `shift_sel`=1, lane i's capture stage loads `scan_in[i]`. `scan_out[i]` always shows the capture stage.
- R3: On a clock edge with `cap_en`=1 and `shift_sel`=0, lane i's capture stage loads `par_in[i]`.
- R4: On a clock edge with `cap_en`=0, the capture stage keeps its value.
- R5: On a clock edge with `upd_en`=1, the hold stage loads the capture stage's value from before that edge. If `cap_en` is also 1 on that edge, the hold stage gets the old capture value, not the newly captured one.
- R6: On a clock edge with `upd_en`=0, the hold stage keeps its value. As a result, `par_out` stays stable in test mode through any number of shift cycles.
- R7: While `test_mode` is 1, `par_out[i]` equals lane i's hold stage, whatever `par_in` is.
- R8: A clock edge with `rst_n`=0 clears both stages of every lane to 0 (synchronous, active low).
- R9: Each lane uses only its own bit of `scan_in`, `par_in` and its own stages. The control inputs are shared by all lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Capture/shift strobe (enable) |
| shift_sel | input | 1 | 1: serial load, 0: parallel capture |
| upd_en | input | 1 | Hold-stage load strobe (enable) |
| test_mode | input | 1 | 1: drive `par_out` from the hold stage |
| scan_in | input | LANES | Serial input per lane |
| par_in | input | LANES | Parallel input per lane (board or core side) |
| par_out | output | LANES | Parallel output per lane |
| scan_out | output | LANES | Capture-stage value per lane |

## Verification
The bench builds the bank with the default of four lanes. This lets distinct per-lane patterns show crosstalk or swapped bits between lanes, and lets walking-one and alternating patterns exercise every lane of both stages.

The bench runs these stimuli:
- Serial sequences with test mode held high, to show that the driven value does not move while bits shift.
- A cycle where capture and update strobe together, to expose the one-cycle ordering between the stages.
- A long random mix of all controls, against a behavioural model.

// File: rtl/bsr_pkg.sv
// Package: bsr_pkg
// Shared types for the boundary-scan cell bank.
// Assumes all strobes are synchronous enables on a single test clock.
package bsr_pkg;

    // Bundle of the shared control strobes, fanned out to every lane
    typedef struct packed {
        logic cap_en;
        logic shift_sel;
        logic upd_en;
        logic test_mode;
    } bsr_ctrl_t;

    // Value both stages take on reset
    localparam logic BSR_RST_VAL = 1'b0;

endpackage

// File: rtl/bsr_capture_stage.sv
// Module: bsr_capture_stage
// Capture/shift flop of one lane. It loads the serial input or the
// parallel input when strobed and holds its value otherwise.
// Assumes a synchronous active-low reset and a single test clock.
module bsr_capture_stage
    import bsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_sel,
    input  logic scan_bit,
    input  logic par_bit,
    output logic cap_q
);

    logic cap_d;

    // Choose serial or parallel source for the next captured value
    always_comb begin
        cap_d = shift_sel ? scan_bit : par_bit;
    end

    // Capture/shift register with enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= BSR_RST_VAL;
        else if (cap_en)
            cap_q <= cap_d;
    end

    p_shift_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && shift_sel) |=> (cap_q == $past(scan_bit)));
    p_par_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !shift_sel) |=> (cap_q == $past(par_bit)));
    p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(cap_q));

endmodule

// File: rtl/bsr_update_stage.sv
// Module: bsr_update_stage
// Hold flop of one lane. It copies the capture flop when strobed and
// otherwise keeps the value that test mode drives out.
// Assumes a synchronous active-low reset and a single test clock.
module bsr_update_stage
    import bsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic cap_q,
    output logic upd_q
);

    // Hold register, loaded from the capture stage on the update strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_q <= BSR_RST_VAL;
        else if (upd_en)
            upd_q <= cap_q;
    end

    p_upd_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (upd_q == $past(cap_q)));
    p_upd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(upd_q));

endmodule

// File: rtl/bsr_drive_mux.sv
// Module: bsr_drive_mux
// Output selector of one lane. It passes the parallel input through in
// normal operation and the hold stage in test mode. Purely combinational.
module bsr_drive_mux (
    input  logic test_mode,
    input  logic par_bit,
    input  logic upd_q,
    output logic out_bit
);

    // Select the driven value for the pin or core side
    always_comb begin
        out_bit = test_mode ? upd_q : par_bit;
    end

endmodule

// File: rtl/bsr_cell_bank.sv
// Module: bsr_cell_bank
// Bank of LANES independent boundary-scan cells sharing one set of
// control strobes. Each lane is a capture stage, a hold stage and an
// output selector. Lanes are not linked: chaining is done outside.
// Assumes a synchronous active-low reset and a single test clock.
module bsr_cell_bank
    import bsr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             shift_sel,
    input  logic             upd_en,
    input  logic             test_mode,
    input  logic [LANES-1:0] scan_in,
    input  logic [LANES-1:0] par_in,
    output logic [LANES-1:0] par_out,
    output logic [LANES-1:0] scan_out
);

    localparam int LANE_MSB = LANES - 1;

    bsr_ctrl_t          ctrl;
    logic [LANE_MSB:0]  cap_vec;
    logic [LANE_MSB:0]  upd_vec;

    // Gather the shared strobes into one bundle
    always_comb begin
        ctrl.cap_en    = cap_en;
        ctrl.shift_sel = shift_sel;
        ctrl.upd_en    = upd_en;
        ctrl.test_mode = test_mode;
    end

    // One cell per lane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bsr_capture_stage u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_en    (ctrl.cap_en),
            .shift_sel (ctrl.shift_sel),
            .scan_bit  (scan_in[i]),
            .par_bit   (par_in[i]),
            .cap_q     (cap_vec[i])
        );

        bsr_update_stage u_upd (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd_en (ctrl.upd_en),
            .cap_q  (cap_vec[i]),
            .upd_q  (upd_vec[i])
        );

        bsr_drive_mux u_mux (
            .test_mode (ctrl.test_mode),
            .par_bit   (par_in[i]),
            .upd_q     (upd_vec[i]),
            .out_bit   (par_out[i])
        );
    end

    // Serial output of every lane is its capture stage
    always_comb begin
        scan_out = cap_vec;
    end

    p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (par_out == par_in));
    p_test_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (par_out == upd_vec));

endmodule

// File: tb/bsr_cell_bank_tb.sv
module bsr_cell_bank_tb;

    localparam int L = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cap_en, shift_sel, upd_en, test_mode;
    logic [L-1:0] scan_in, par_in;
    logic [L-1:0] par_out, scan_out;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural model state
    logic [L-1:0] m_cap, m_upd;

    always #5 clk = ~clk;

    bsr_cell_bank #(.LANES(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_sel(shift_sel),
        .upd_en(upd_en), .test_mode(test_mode), .scan_in(scan_in),
        .par_in(par_in), .par_out(par_out), .scan_out(scan_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [L-1:0] act, input logic [L-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, check par_out before the edge,
    // advance the model at the edge, then check scan_out after it
    task automatic step(input logic ce, input logic ss, input logic ue,
                        input logic tm, input logic [L-1:0] si,
                        input logic [L-1:0] pi, input string tag);
        logic [L-1:0] nc, nu;
        cap_en = ce; shift_sel = ss; upd_en = ue; test_mode = tm;
        scan_in = si; par_in = pi;
        #1;
        chk(tag, "par_out", par_out, tm ? m_upd : pi);
        @(posedge clk);
        if (!rst_n) begin
            nc = '0; nu = '0;
        end else begin
            nc = ce ? (ss ? si : pi) : m_cap;
            nu = ue ? m_cap : m_upd;
        end
        m_cap = nc; m_upd = nu;
        @(negedge clk);
        chk(tag, "scan_out", scan_out, m_cap);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_cap = 'x; m_upd = 'x;
        rst_n = 1'b0;
        @(negedge clk);
        // R8: reset clears both stages even with strobes active
        step(1, 1, 1, 0, 4'hF, 4'hF, "R8");
        step(1, 0, 1, 1, 4'hF, 4'hA, "R8");
        rst_n = 1'b1;
        // R1: pass-through for several patterns
        step(0, 0, 0, 0, 4'h0, 4'h5, "R1");
        step(0, 0, 0, 0, 4'hF, 4'hA, "R1");
        step(0, 1, 0, 0, 4'h3, 4'hC, "R1");
        // R3: parallel capture, then R5 update, then R7 drive
        step(1, 0, 0, 0, 4'h0, 4'h9, "R3");
        step(0, 0, 1, 0, 4'hF, 4'h0, "R5");
        step(0, 0, 0, 1, 4'h0, 4'h6, "R7");
        step(0, 1, 0, 1, 4'hF, 4'hF, "R7");
        // R4: hold with cap_en low
        step(0, 1, 0, 1, 4'hF, 4'hF, "R4");
        step(0, 0, 0, 0, 4'h0, 4'h0, "R4");
        // R2 + R6: shift walking ones with test_mode high, hold stable
        for (int k = 0; k < 6; k++)
            step(1, 1, 0, 1, 4'(1 << (k % L)), 4'hF, "R6");
        step(1, 1, 0, 1, 4'hA, 4'h0, "R2");
        step(1, 1, 0, 1, 4'h5, 4'hF, "R2");
        // R5: same-edge capture and update -> hold gets old capture
        step(1, 0, 1, 1, 4'h0, 4'h3, "R5");
        step(0, 0, 0, 1, 4'h0, 4'hC, "R5");
        step(0, 0, 1, 1, 4'h0, 4'hC, "R5");
        step(0, 0, 0, 1, 4'h0, 4'h0, "R7");
        // R9: random mix of all controls with per-lane distinct data
        for (int k = 0; k < 300; k++) begin
            logic [3:0] c;
            c = 4'($urandom);
            step(c[0], c[1], c[2], c[3], 4'($urandom), 4'($urandom), "R9");
        end
        // R8: reset in mid-operation
        rst_n = 1'b0;
        step(1, 1, 1, 1, 4'hF, 4'hF, "R8");
        rst_n = 1'b1;
        step(0, 0, 0, 1, 4'hF, 4'hF, "R8");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule